// File: doc/BRIEF.md
# EEPROM Software Write-Protection Sequencer

This block sits on the byte-wide write path in front of an EEPROM array. It watches every bus write. It picks out the keyed multi-write commands that switch software write protection on or off. While protection is on, it stops ordinary writes from reaching the array. The keys are fixed data bytes written to two addresses that lie on different EEPROM pages, so a command can never be mistaken for an ordinary write confined to one page.

Each command step must follow the previous one within a bounded number of microsecond ticks, or the partial command is dropped. Turning protection on takes effect immediately. Turning it off takes effect only after a write-cycle delay, counted in microsecond ticks, and a busy flag is raised during that delay.

The array itself, its page buffer and its programming timing live outside this block. The block drives a per-write enable qualifier, and the array honours a write only when that qualifier is high.

Top module: `eeprom_sdp_guard`

## Requirements
- R1: After reset, `protOn` is 1, `unlockBusy` is 0, and `arrayWrEn` is 0 while no write is strobed.
- R2: The writes AAh@5555h, then 55h@2AAAh, then A0h@5555h set `protOn` to 1 from the cycle after the third write, and clear `unlockBusy`.
- R3: The six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h, issued while protected, raise `unlockBusy` from the cycle after the sixth write, with `protOn` still 1. Issued while unprotected, they leave `unlockBusy` at 0.
- R4: Once `unlockBusy` is high, it stays high for exactly `WC_TICKS` `usTick` pulses. After the last of those ticks, `protOn` and `unlockBusy` are both 0 from the next cycle.
- R5: While `protOn` is 0, an ordinary write (one that does not match the expected command step) raises `arrayWrEn` in the same cycle as `wrStrobe`.
- R6: While `protOn` is 1, including during the unlock delay, `arrayWrEn` stays 0 for every write.
- R7: A write that does not match the expected address/data pair of the current step returns the sequencer to idle. That write is handled as an ordinary write, so a later key does not complete the abandoned command.
- R8: Between command steps, up to `GAP_LIMIT` (default 120) `usTick` pulses are tolerated. On tick number `GAP_LIMIT+1` with no write, the partial command is abandoned.
- R9: A write that matches the expected command step never raises `arrayWrEn`, whatever the protection state. This keeps command bytes out of the array and refuses any page-mode burst during a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStrobe | input | 1 | One-cycle write strobe from the bus |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data byte |
| usTick | input | 1 | One-cycle pulse every microsecond |
| protOn | output | 1 | Software write protection active |
| unlockBusy | output | 1 | Write-cycle delay after an unlock command is running |
| arrayWrEn | output | 1 | Qualified write enable toward the array |

## Verification
On every cycle, assertions check the following:
- a strobed write is never passed to the array while protection is on;
- `unlockBusy` is never high without `protOn`;
- the gap and delay counters stay inside their limits;
- any non-command write returns the sequencer to idle.

The exact tick counts at the edges of the timeout and of the unlock delay can only be shown by the bench's scenarios. The same holds for the fact that an abandoned or broken command leaves protection unchanged, and for the routing of keys into the array when the block is unprotected.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_DISPRE,
    ST_DKEY1,
    ST_DKEY2
  } seqStep_t;

  // strobes from control toward datapath
  typedef struct packed {
    logic consume;      // current write belongs to a command
    logic setProt;      // lock command completed
    logic startUnlock;  // unlock command completed
  } ctrlStb_t;

endpackage

// File: rtl/sdp_ctrl.sv
module sdp_ctrl
  import sdp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int GAP_LIMIT = 120,
  parameter logic [ADDR_W-1:0] ADDR_A  = 16'h5555,
  parameter logic [ADDR_W-1:0] ADDR_B  = 16'h2AAA,
  parameter logic [DATA_W-1:0] KEY_1   = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_2   = 8'h55,
  parameter logic [DATA_W-1:0] OP_LOCK = 8'hA0,
  parameter logic [DATA_W-1:0] OP_PRE  = 8'h80,
  parameter logic [DATA_W-1:0] OP_FREE = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              usTick,
  output ctrlStb_t          stb
);

  localparam int GAP_W = $clog2(GAP_LIMIT + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(GAP_LIMIT);

  seqStep_t step, nextStep;
  logic [GAP_W-1:0] gapCnt;
  logic onA, onB;

  assign onA = (wrAddr == ADDR_A);
  assign onB = (wrAddr == ADDR_B);

  always_comb begin
    nextStep = step;
    stb      = '0;
    if (wrStrobe) begin
      nextStep = ST_IDLE;  // any mismatch drops the command
      unique case (step)
        ST_IDLE:   if (onA && wrData == KEY_1) begin nextStep = ST_KEY1; stb.consume = 1'b1; end
        ST_KEY1:   if (onB && wrData == KEY_2) begin nextStep = ST_KEY2; stb.consume = 1'b1; end
        ST_KEY2: begin
          if (onA && wrData == OP_LOCK) begin
            stb.consume = 1'b1;
            stb.setProt = 1'b1;
          end else if (onA && wrData == OP_PRE) begin
            nextStep    = ST_DISPRE;
            stb.consume = 1'b1;
          end
        end
        ST_DISPRE: if (onA && wrData == KEY_1) begin nextStep = ST_DKEY1; stb.consume = 1'b1; end
        ST_DKEY1:  if (onB && wrData == KEY_2) begin nextStep = ST_DKEY2; stb.consume = 1'b1; end
        ST_DKEY2: begin
          if (onA && wrData == OP_FREE) begin
            stb.consume     = 1'b1;
            stb.startUnlock = 1'b1;
          end
        end
        default: nextStep = ST_IDLE;
      endcase
    end else if (usTick && step != ST_IDLE && gapCnt == GAP_MAX) begin
      nextStep = ST_IDLE;  // inter-write gap exceeded
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step   <= ST_IDLE;
      gapCnt <= '0;
    end else begin
      step <= nextStep;
      if (wrStrobe || step == ST_IDLE) gapCnt <= '0;
      else if (usTick) gapCnt <= (gapCnt == GAP_MAX) ? '0 : gapCnt + 1'b1;
    end
  end

  // R8: gap counter never passes its limit
  a_r8_gap_bound: assert property (@(posedge clk) disable iff (!rstN)
    gapCnt <= GAP_MAX);

  // R7: an unmatched write leaves the sequencer idle
  a_r7_idle_after_miss: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !stb.consume) |=> (step == ST_IDLE));

  // R9: only a strobed write can be consumed
  a_r9_consume_on_write: assert property (@(posedge clk) disable iff (!rstN)
    stb.consume |-> wrStrobe);

endmodule

// File: rtl/sdp_datapath.sv
module sdp_datapath
  import sdp_pkg::*;
#(
  parameter int   WC_TICKS      = 10000,
  parameter logic PROT_AT_RESET = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrStrobe,
  input  logic     usTick,
  input  ctrlStb_t stb,
  output logic     protOn,
  output logic     unlockBusy,
  output logic     arrayWrEn
);

  localparam int WC_W = $clog2(WC_TICKS + 1);
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(WC_TICKS - 1);

  logic [WC_W-1:0] wcCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protOn     <= PROT_AT_RESET;
      unlockBusy <= 1'b0;
      wcCnt      <= '0;
    end else if (stb.setProt) begin
      protOn     <= 1'b1;
      unlockBusy <= 1'b0;
      wcCnt      <= '0;
    end else if (stb.startUnlock && protOn) begin
      unlockBusy <= 1'b1;
      wcCnt      <= '0;
    end else if (unlockBusy && usTick) begin
      if (wcCnt == WC_LAST) begin
        unlockBusy <= 1'b0;
        protOn     <= 1'b0;
        wcCnt      <= '0;
      end else begin
        wcCnt <= wcCnt + 1'b1;
      end
    end
  end

  assign arrayWrEn = wrStrobe && !stb.consume && !protOn;

  // R6: nothing reaches the array while protected
  a_r6_block_when_prot: assert property (@(posedge clk) disable iff (!rstN)
    arrayWrEn |-> !protOn);

  // R4: the delay only runs while still protected
  a_r4_busy_implies_prot: assert property (@(posedge clk) disable iff (!rstN)
    unlockBusy |-> protOn);

  // R4: delay counter stays in range
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    wcCnt <= WC_LAST);

  // R2: a lock command takes hold on the next cycle
  a_r2_lock_holds: assert property (@(posedge clk) disable iff (!rstN)
    stb.setProt |=> (protOn && !unlockBusy));

  // R3: an unlock command while protected starts the delay
  a_r3_unlock_starts: assert property (@(posedge clk) disable iff (!rstN)
    (stb.startUnlock && !stb.setProt && protOn) |=> unlockBusy);

endmodule

// File: rtl/eeprom_sdp_guard.sv
module eeprom_sdp_guard
  import sdp_pkg::*;
#(
  parameter int   ADDR_W        = 16,
  parameter int   DATA_W        = 8,
  parameter int   GAP_LIMIT     = 120,
  parameter int   WC_TICKS      = 10000,
  parameter logic PROT_AT_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              usTick,
  output logic              protOn,
  output logic              unlockBusy,
  output logic              arrayWrEn
);

  ctrlStb_t stb;

  sdp_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .GAP_LIMIT(GAP_LIMIT)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrStrobe(wrStrobe),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .usTick  (usTick),
    .stb     (stb)
  );

  sdp_datapath #(
    .WC_TICKS     (WC_TICKS),
    .PROT_AT_RESET(PROT_AT_RESET)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .wrStrobe  (wrStrobe),
    .usTick    (usTick),
    .stb       (stb),
    .protOn    (protOn),
    .unlockBusy(unlockBusy),
    .arrayWrEn (arrayWrEn)
  );

endmodule

// File: tb/tb_eeprom_sdp_guard.sv
module tb_eeprom_sdp_guard;

  localparam int WC = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStrobe = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic usTick = 1'b0;
  logic protOn, unlockBusy, arrayWrEn;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  eeprom_sdp_guard #(.GAP_LIMIT(120), .WC_TICKS(WC)) dut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrAddr(wrAddr),
    .wrData(wrData), .usTick(usTick), .protOn(protOn),
    .unlockBusy(unlockBusy), .arrayWrEn(arrayWrEn)
  );

  // {ticks before write, addr, data, expWrEn, expProt, expBusy, req}
  localparam logic [38:0] VEC [28] = '{
    {8'd0,   16'h1234, 8'h11, 1'b0, 1'b1, 1'b0, 4'd6}, // R6 blocked at reset
    {8'd0,   16'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, 4'd9}, // R9
    {8'd0,   16'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, 4'd9}, // R9
    {8'd0,   16'h5555, 8'h80, 1'b0, 1'b1, 1'b0, 4'd3}, // R3
    {8'd0,   16'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, 4'd3}, // R3
    {8'd0,   16'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, 4'd3}, // R3
    {8'd0,   16'h5555, 8'h20, 1'b0, 1'b1, 1'b1, 4'd3}, // R3 delay starts
    {8'd20,  16'h0100, 8'h3C, 1'b1, 1'b0, 1'b0, 4'd4}, // R4 unlocked after WC ticks
    {8'd0,   16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 key consumed while open
    {8'd0,   16'h0200, 8'h77, 1'b1, 1'b0, 1'b0, 4'd7}, // R7 mismatch passes
    {8'd0,   16'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0, 4'd7}, // R7 idle again, ordinary
    {8'd0,   16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 4'd2}, // R2
    {8'd0,   16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, 4'd2}, // R2
    {8'd0,   16'h5555, 8'hA0, 1'b0, 1'b1, 1'b0, 4'd2}, // R2 locked
    {8'd0,   16'h0300, 8'h99, 1'b0, 1'b1, 1'b0, 4'd6}, // R6
    {8'd0,   16'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, 4'd8}, // R8
    {8'd120, 16'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, 4'd8}, // R8 gap at limit
    {8'd120, 16'h5555, 8'h80, 1'b0, 1'b1, 1'b0, 4'd8}, // R8
    {8'd120, 16'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, 4'd8}, // R8
    {8'd0,   16'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, 4'd8}, // R8
    {8'd0,   16'h5555, 8'h20, 1'b0, 1'b1, 1'b1, 4'd8}, // R8 command survived
    {8'd20,  16'h0400, 8'hC3, 1'b1, 1'b0, 1'b0, 4'd5}, // R5 plain write passes
    {8'd0,   16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 4'd8}, // R8
    {8'd121, 16'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0, 4'd8}, // R8 abandoned -> ordinary
    {8'd0,   16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 4'd7}, // R7
    {8'd0,   16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, 4'd7}, // R7
    {8'd0,   16'h0500, 8'h66, 1'b1, 1'b0, 1'b0, 4'd7}, // R7 breaks command
    {8'd0,   16'h5555, 8'hA0, 1'b1, 1'b0, 1'b0, 4'd7}  // R7 lock not completed
  };

  task automatic chk(input int req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) usTick = 1'b1;
      @(negedge clk) usTick = 1'b0;
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d, input int req,
                          input logic expEn, input logic expProt, input logic expBusy);
    @(negedge clk);
    wrAddr = a; wrData = d; wrStrobe = 1'b1;
    #1 chk(req, "arrayWrEn", arrayWrEn, expEn);
    @(negedge clk);
    wrStrobe = 1'b0;
    chk(req, "protOn", protOn, expProt);
    chk(req, "unlockBusy", unlockBusy, expBusy);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(1, "protOn reset", protOn, 1'b1);
    chk(1, "unlockBusy reset", unlockBusy, 1'b0);
    chk(1, "arrayWrEn idle", arrayWrEn, 1'b0);

    for (int v = 0; v < 28; v++) begin
      tick(int'(VEC[v][38:31]));
      busWrite(VEC[v][30:15], VEC[v][14:7], int'(VEC[v][3:0]),
               VEC[v][6], VEC[v][5], VEC[v][4]);
    end

    // Unlocked, idle. First lock the array again (R2).
    busWrite(16'h5555, 8'hAA, 2, 1'b0, 1'b0, 1'b0);
    busWrite(16'h2AAA, 8'h55, 2, 1'b0, 1'b0, 1'b0);
    busWrite(16'h5555, 8'hA0, 2, 1'b0, 1'b1, 1'b0);
    // Unlock, then check the delay at its boundary (R4) and blocking during it (R6).
    busWrite(16'h5555, 8'hAA, 3, 1'b0, 1'b1, 1'b0);
    busWrite(16'h2AAA, 8'h55, 3, 1'b0, 1'b1, 1'b0);
    busWrite(16'h5555, 8'h80, 3, 1'b0, 1'b1, 1'b0);
    busWrite(16'h5555, 8'hAA, 3, 1'b0, 1'b1, 1'b0);
    busWrite(16'h2AAA, 8'h55, 3, 1'b0, 1'b1, 1'b0);
    busWrite(16'h5555, 8'h20, 3, 1'b0, 1'b1, 1'b1);
    tick(WC - 1);
    chk(4, "busy before last tick", unlockBusy, 1'b1);
    chk(4, "prot before last tick", protOn, 1'b1);
    busWrite(16'h0700, 8'h01, 6, 1'b0, 1'b1, 1'b1);  // R6 during delay
    tick(1);
    chk(4, "busy after last tick", unlockBusy, 1'b0);
    chk(4, "prot after last tick", protOn, 1'b0);

    // R3: an unlock command while already unprotected starts no delay.
    busWrite(16'h5555, 8'hAA, 3, 1'b0, 1'b0, 1'b0);
    busWrite(16'h2AAA, 8'h55, 3, 1'b0, 1'b0, 1'b0);
    busWrite(16'h5555, 8'h80, 3, 1'b0, 1'b0, 1'b0);
    busWrite(16'h5555, 8'hAA, 3, 1'b0, 1'b0, 1'b0);
    busWrite(16'h2AAA, 8'h55, 3, 1'b0, 1'b0, 1'b0);
    busWrite(16'h5555, 8'h20, 3, 1'b0, 1'b0, 1'b0);
    busWrite(16'h0800, 8'h42, 5, 1'b1, 1'b0, 1'b0);  // R5

    // R1: reset brings protection back.
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    chk(1, "protOn after reset", protOn, 1'b1);
    chk(1, "unlockBusy after reset", unlockBusy, 1'b0);

    summary();
  end

endmodule